// File: doc/BRIEF.md
# I2C Slave Maskable Address Matcher

This block decides whether an I2C slave is being addressed. A byte deserializer upstream presents each received byte with a one-cycle valid strobe, and separate one-cycle pulses mark START and STOP conditions. The matcher treats the first byte after a START as an address byte. It compares that byte against a programmed slave address through a per-bit don't-care mask and reports a one-cycle match pulse together with the latched read/write bit.

Two addressing modes are supported. In 7-bit mode the upper seven bits of the first byte are compared and the lowest bit is the direction bit. In 10-bit mode the first byte must carry a fixed five-bit prefix, the two top address bits and the direction bit. This byte is always compared exactly and ignores the mask. A matching high byte in write direction arms the compare of the next byte against the low eight address bits, and this compare uses all eight mask bits. After a complete 10-bit match, a repeated START followed by the same high byte in read direction selects the slave again without a low byte.

The mask starts at all ones, so the compare is exact until software writes a mask. The mask shares its register location with the low address register. A dedicated mode value redirects that location to the mask, and in that mode the mask accepts writes only while the port enable is low.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset the low address register reads 0x00, the high address register reads 0x00 and the mask reads 0xFF. Select 0 reads the low address register in every mode except mask-access mode (mode_sel = 2), where it reads the mask. Select 1 reads the two high address bits in bits 1:0.
- R2: In 7-bit mode (mode_sel = 0) with port_en = 1, the first byte after a START matches when bits 7:1 equal the low address register bits 7:1 wherever the mask bit is 1. addr_match pulses for one cycle, in the cycle after the strobe, and rw_bit takes received bit 0 in that same cycle.
- R3: A mask bit of 0 makes the corresponding received bit a don't-care in the compare.
- R4: In 7-bit mode, received bit 0, address bit 0 and mask bit 0 take no part in the match.
- R5: In 10-bit mode (mode_sel = 1), the first byte after a START passes when bits 7:3 are 11110 and bits 2:1 equal the two high address bits, whatever the mask holds. A pass raises hi_byte for one cycle, in the cycle after the strobe.
- R6: After a passing high byte with bit 0 = 0, the next byte is compared on all eight bits against the low address register through the mask. A pass gives addr_match with rw_bit = 0.
- R7: After a complete 10-bit match and a repeated START, a passing high byte with bit 0 = 1 gives addr_match with rw_bit = 1. Without a prior complete match since the last STOP, the same byte gives hi_byte only.
- R8: A START makes the next byte a first address byte again, and it drops any pending low-byte compare. A STOP drops all sequence state, including the memory of a complete 10-bit match. Bytes that are not first address bytes or awaited low bytes never match.
- R9: In mask-access mode a write to select 0 goes to the mask, and it takes effect only while port_en = 0. Outside that mode the write goes to the low address register.
- R10: No match and no hi_byte occur in mask-access mode, in the off mode (mode_sel = 3), or while port_en = 0.
- R11: A START or STOP in the same cycle as a byte strobe takes priority, and that byte is neither matched nor counted as an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe qualifying rx_byte |
| start_det | input | 1 | START or repeated START pulse |
| stop_det | input | 1 | STOP pulse |
| mode_sel | input | 2 | 0 = 7-bit, 1 = 10-bit, 2 = mask access, 3 = off |
| port_en | input | 1 | Serial port enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = low address or mask location, 1 = high address bits |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel |
| addr_match | output | 1 | One-cycle full address match pulse |
| hi_byte | output | 1 | One-cycle pulse for a passing 10-bit high byte |
| rw_bit | output | 1 | Direction bit latched at the last match |

## Verification
The bench builds the block with the package defaults: an 8-bit byte, two high address bits and a five-bit 10-bit prefix. These defaults put every address bit and every mask bit within reach of directed bytes. The mask values used, 0xF0 and 0xF1, are chosen so that applying the mask to the high byte, or dropping mask bit 0 from the 10-bit low compare, would change the outcome. Repeated-START sequences with and without an intervening STOP exercise the stored full-match state.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    localparam int BYTE_W = 8;
    localparam int HI_W   = 2;
    localparam int PFX_W  = BYTE_W - HI_W - 1;
    localparam logic [PFX_W-1:0] HI_PREFIX = 5'b11110;

    typedef enum logic [1:0] {
        AM_MODE_7      = 2'd0,
        AM_MODE_10     = 2'd1,
        AM_MODE_MSKACC = 2'd2,
        AM_MODE_OFF    = 2'd3
    } am_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [HI_W-1:0]   hi;
        logic [BYTE_W-1:0] msk;
    } am_cfg_t;

    typedef struct packed {
        logic lo7_ok;
        logic lo10_ok;
        logic hi_ok;
        logic rw;
    } am_cmp_t;

    function automatic logic matching_mode(input am_mode_e m);
        return (m == AM_MODE_7) || (m == AM_MODE_10);
    endfunction
endpackage

// File: rtl/am_regs.sv
module am_regs
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              sel,
    input  logic [BYTE_W-1:0] wdata,
    input  am_mode_e          mode,
    input  logic              port_en,
    output am_cfg_t           cfg,
    output logic [BYTE_W-1:0] rdata
);
    localparam int PAD_W = BYTE_W - HI_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.lo  <= '0;
            cfg.hi  <= '0;
            cfg.msk <= '1;
        end else if (wr) begin
            if (!sel) begin
                if (mode == AM_MODE_MSKACC) begin
                    if (!port_en) cfg.msk <= wdata;
                end else begin
                    cfg.lo <= wdata;
                end
            end else begin
                cfg.hi <= wdata[HI_W-1:0];
            end
        end
    end

    always_comb begin
        if (sel)                          rdata = {{PAD_W{1'b0}}, cfg.hi};
        else if (mode == AM_MODE_MSKACC)  rdata = cfg.msk;
        else                              rdata = cfg.lo;
    end
endmodule

// File: rtl/am_cmp.sv
module am_cmp
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] rx,
    input  am_cfg_t           cfg,
    output am_cmp_t           res
);
    logic [BYTE_W-1:0] diff;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign diff[i] = (rx[i] ^ cfg.lo[i]) & cfg.msk[i];
    end

    always_comb begin
        res.lo7_ok  = ~|diff[BYTE_W-1:1];
        res.lo10_ok = ~|diff;
        res.hi_ok   = (rx[BYTE_W-1:HI_W+1] == HI_PREFIX) && (rx[HI_W:1] == cfg.hi);
        res.rw      = rx[0];
    end
endmodule

// File: rtl/am_seq.sv
module am_seq
    import i2c_am_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_valid,
    input  logic     start_det,
    input  logic     stop_det,
    input  am_mode_e mode,
    input  logic     port_en,
    input  am_cmp_t  cmp,
    output logic     match_o,
    output logic     hi_o,
    output logic     rw_o
);
    logic await_first, await_lo, sel10;
    logic live;

    assign live = port_en && matching_mode(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            await_first <= 1'b0;
            await_lo    <= 1'b0;
            sel10       <= 1'b0;
            match_o     <= 1'b0;
            hi_o        <= 1'b0;
            rw_o        <= 1'b0;
        end else begin
            match_o <= 1'b0;
            hi_o    <= 1'b0;
            if (stop_det) begin
                await_first <= 1'b0;
                await_lo    <= 1'b0;
                sel10       <= 1'b0;
            end else if (start_det) begin
                await_first <= 1'b1;
                await_lo    <= 1'b0;
            end else if (rx_valid) begin
                await_first <= 1'b0;
                await_lo    <= 1'b0;
                if (live && await_first) begin
                    if (mode == AM_MODE_7) begin
                        if (cmp.lo7_ok) begin
                            match_o <= 1'b1;
                            rw_o    <= cmp.rw;
                        end
                    end else if (cmp.hi_ok) begin
                        hi_o <= 1'b1;
                        if (!cmp.rw) begin
                            await_lo <= 1'b1;
                        end else if (sel10) begin
                            match_o <= 1'b1;
                            rw_o    <= 1'b1;
                        end
                    end
                end else if (live && await_lo && mode == AM_MODE_10) begin
                    if (cmp.lo10_ok) begin
                        match_o <= 1'b1;
                        rw_o    <= 1'b0;
                        sel10   <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        mode_sel,
    input  logic              port_en,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              addr_match,
    output logic              hi_byte,
    output logic              rw_bit
);
    am_mode_e mode;
    am_cfg_t  cfg_q;
    am_cmp_t  cmp_r;

    assign mode = am_mode_e'(mode_sel);

    am_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .mode(mode), .port_en(port_en), .cfg(cfg_q), .rdata(reg_rdata)
    );

    am_cmp u_cmp (.rx(rx_byte), .cfg(cfg_q), .res(cmp_r));

    am_seq u_seq (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .start_det(start_det),
        .stop_det(stop_det), .mode(mode), .port_en(port_en), .cmp(cmp_r),
        .match_o(addr_match), .hi_o(hi_byte), .rw_o(rw_bit)
    );
endmodule

// File: rtl/am_checker.sv
module am_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic       start_det,
    input logic       stop_det,
    input logic [1:0] mode_sel,
    input logic       port_en,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [7:0] msk,
    input logic       addr_match,
    input logic       hi_byte
);
    p_match_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        addr_match |-> $past(rx_valid));

    p_match_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        addr_match |=> !addr_match);

    p_hi_only_ten_r5: assert property (@(posedge clk) disable iff (rst)
        hi_byte |-> ($past(mode_sel) == 2'd1));

    p_msk_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel && mode_sel == 2'd2 && port_en) |=> $stable(msk));

    p_no_match_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (addr_match || hi_byte) |-> ($past(mode_sel) <= 2'd1 && $past(port_en)));

    p_edge_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (start_det || stop_det) |=> (!addr_match && !hi_byte));
endmodule

bind i2c_addr_matcher am_checker u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .start_det(start_det),
    .stop_det(stop_det), .mode_sel(mode_sel), .port_en(port_en),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .msk(cfg_q.msk),
    .addr_match(addr_match), .hi_byte(hi_byte)
);

// File: tb/sim_i2c_addr_matcher.sv
`timescale 1ns/1ps
module sim_i2c_addr_matcher;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0, start_det = 1'b0, stop_det = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       port_en = 1'b1;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       addr_match, hi_byte, rw_bit;

    int n_cmp = 0, n_bad = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];
    logic       v_q = 1'b0;

    always #2.5 clk = ~clk;

    i2c_addr_matcher u0 (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .start_det(start_det), .stop_det(stop_det), .mode_sel(mode_sel),
        .port_en(port_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .addr_match(addr_match), .hi_byte(hi_byte), .rw_bit(rw_bit)
    );

    always @(posedge clk) v_q <= rx_valid;

    // monitor: pops one expectation per strobed byte
    always @(negedge clk) begin
        if (v_q && exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (addr_match !== e[2] || hi_byte !== e[1] || (e[2] && rw_bit !== e[0])) begin
                n_bad++;
                $display("FAIL %s: match/hi/rw = %b%b%b expected %b%b%b",
                         t, addr_match, hi_byte, rw_bit, e[2], e[1], e[0]);
            end
        end else if (!rst && (addr_match || hi_byte)) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2: unsolicited match/hi = %b%b expected 00", addr_match, hi_byte);
        end
    end

    task automatic send(input logic [7:0] b, input bit m, input bit h, input bit r,
                        input bit s, input bit p, input string tag);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1; start_det = s; stop_det = p;
        exp_q.push_back({m, h, r});
        tag_q.push_back(tag);
        @(negedge clk);
        rx_valid = 1'b0; start_det = 1'b0; stop_det = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_det = 1'b1;
        @(negedge clk); stop_det = 1'b0;
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic s, input logic [7:0] e, input string tag);
        @(negedge clk); reg_sel = s;
        #1;
        n_cmp++;
        if (reg_rdata !== e) begin
            n_bad++;
            $display("FAIL %s: rdata = %h expected %h", tag, reg_rdata, e);
        end
    endtask

    task automatic set_mask(input logic [7:0] m);
        mode_sel = 2'd2; port_en = 1'b0;
        wr(1'b0, m);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values and read redirection
        chk_rd(1'b0, 8'h00, "R1 low addr reset");
        chk_rd(1'b1, 8'h00, "R1 high addr reset");
        mode_sel = 2'd2;
        chk_rd(1'b0, 8'hFF, "R1 mask reset");
        mode_sel = 2'd0;

        // R2 7-bit exact compare
        wr(1'b0, 8'hA4);
        do_start(); send(8'hA5, 1, 0, 1, 0, 0, "R2 read match");
        do_start(); send(8'hA4, 1, 0, 0, 0, 0, "R2 write match");
        do_start(); send(8'hA6, 0, 0, 0, 0, 0, "R2 miss");
        send(8'hA4, 0, 0, 0, 0, 0, "R8 data byte no start");
        // R4 address bit 0 ignored in 7-bit
        wr(1'b0, 8'hA5);
        do_start(); send(8'hA4, 1, 0, 0, 0, 0, "R4 addr bit0 ignored");
        // R11 start with strobe
        send(8'hA4, 0, 0, 0, 1, 0, "R11 start wins");
        send(8'hA4, 1, 0, 0, 0, 0, "R11 next byte is first");

        // R9 mask access locked while enabled
        mode_sel = 2'd2; port_en = 1'b1;
        wr(1'b0, 8'h00);
        chk_rd(1'b0, 8'hFF, "R9 mask write blocked");
        set_mask(8'hF0);
        chk_rd(1'b0, 8'hF0, "R9 mask written");
        mode_sel = 2'd0;
        chk_rd(1'b0, 8'hA5, "R9 low addr kept");
        // R10 no matching when not live
        do_start(); send(8'hA4, 0, 0, 0, 0, 0, "R10 port disabled");
        port_en = 1'b1; mode_sel = 2'd2;
        do_start(); send(8'hA4, 0, 0, 0, 0, 0, "R10 mask-access mode");
        mode_sel = 2'd3;
        do_start(); send(8'hA4, 0, 0, 0, 0, 0, "R10 off mode");
        mode_sel = 2'd0;
        // R3 masked bits don't care
        do_start(); send(8'hAB, 1, 0, 1, 0, 0, "R3 masked low nibble");
        do_start(); send(8'hB4, 0, 0, 0, 0, 0, "R3 unmasked bit differs");

        // 10-bit, mask 0xF0, hi = 2'b10, lo = 0x3C
        wr(1'b1, 8'h02);
        wr(1'b0, 8'h3C);
        mode_sel = 2'd1;
        do_start(); send(8'hF6, 0, 0, 0, 0, 0, "R5 high exact despite mask");
        do_start(); send(8'hF4, 0, 1, 0, 0, 0, "R5 high pass");
        send(8'h35, 1, 0, 0, 0, 0, "R6 low masked match");
        // R7 repeated start read
        do_start(); send(8'hF5, 1, 1, 1, 0, 0, "R7 read after full match");
        do_stop();
        do_start(); send(8'hF5, 0, 1, 0, 0, 0, "R7 read without full match");
        // R6 mask bit 0 active in 10-bit
        set_mask(8'hF1);
        mode_sel = 2'd1; port_en = 1'b1;
        do_start(); send(8'hF4, 0, 1, 0, 0, 0, "R6 high pass");
        send(8'h3D, 0, 0, 0, 0, 0, "R6 bit0 compared");
        // R8 start drops pending low byte
        do_start(); send(8'hF4, 0, 1, 0, 0, 0, "R8 high pass");
        do_start(); send(8'h3C, 0, 0, 0, 0, 0, "R8 low byte after restart");
        // R11 stop with low byte
        do_start(); send(8'hF4, 0, 1, 0, 0, 0, "R11 high pass");
        send(8'h3C, 0, 0, 0, 0, 1, "R11 stop wins");
        do_start(); send(8'hF4, 0, 1, 0, 0, 0, "R6 high pass again");
        send(8'h3C, 1, 0, 0, 0, 0, "R6 exact low match");

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule